// File: doc/BRIEF.md
# Pipelined Dual-Port RAM with 9-bit Byte Lanes

This block is a true dual-port synchronous memory. Each port has its own clock. Both ports can read and write every location. The depth is set by the address-width parameter, and a word is 18 bits made of two 9-bit lanes. A port samples its address, write data, lane enables, direction and its pair of chip selects on the rising edge of its clock. The write lands in memory in the following cycle. A read passes through an output register, so the data and lane drive flags appear after the second rising edge, counted from the edge that sampled the request.

The pins that would be tri-stated are instead a data bus and a per-lane drive flag. A flag of 1 means the lane is driven, and 0 means high impedance. An active-low output enable clears every drive flag at once, with no clock involved. The registered state underneath is left unchanged. A port that was deselected, or has just left reset, must see two consecutive selected cycles before its outputs drive again.

Top module: `dpl_ram`

## Requirements
- R1: A port is selected only when its low-active select is 0 and its high-active select is 1. In every other combination the port writes nothing, and its drive flags are 0 for the resulting output cycle.
- R2: A selected cycle with direction 0 is a write. Lane 0 (data bits 8:0) is written only when lane enable bit 0 is 0. Lane 1 (bits 17:9) is written only when enable bit 1 is 0. Lower-only, upper-only and both-lane writes are all valid, and a lane left disabled keeps its old contents.
- R3: A selected cycle with direction 1 is a read. Its word appears on the read-data output after the second rising edge, counted from the edge that sampled the request.
- R4: For a read, each lane's drive flag is 1 in the output cycle only if that lane's enable was 0. A write cycle or a deselected cycle gives drive flags 00 in its output cycle.
- R5: While the output enable is 1, both drive flags are 0 with no clock involved. When the enable returns to 0, the registered flags reappear, and the read data is not altered.
- R6: After reset or after a deselected cycle, a read issued in the first selected cycle gives drive flags 00. A read in the second consecutive selected cycle drives normally.
- R7: A word written on one port is returned by a later read of the same address on the other port.
- R8: When one port writes and the other reads the same address in the same cycle of a shared clock, the read returns the old word. A later read returns the new word.
- R9: In reset, the read data is 0 and both drive flags are 0.
- R10: The read-data output holds its value through every output cycle that does not come from an enabled read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aClk | input | 1 | Port A clock |
| aRstN | input | 1 | Port A asynchronous reset, active low |
| aCsN | input | 1 | Port A select, active low |
| aCs | input | 1 | Port A select, active high |
| aRdWrN | input | 1 | Port A direction: 1 read, 0 write |
| aLaneN | input | 2 | Port A lane enables, active low, bit 0 = bits 8:0 |
| aAddr | input | ADDR_W | Port A word address |
| aWdata | input | 18 | Port A write data |
| aOutEnN | input | 1 | Port A output enable, active low, unclocked |
| aRdata | output | 18 | Port A registered read data |
| aLaneDrv | output | 2 | Port A per-lane drive flags (1 = driven) |
| bClk | input | 1 | Port B clock |
| bRstN | input | 1 | Port B asynchronous reset, active low |
| bCsN | input | 1 | Port B select, active low |
| bCs | input | 1 | Port B select, active high |
| bRdWrN | input | 1 | Port B direction: 1 read, 0 write |
| bLaneN | input | 2 | Port B lane enables, active low, bit 0 = bits 8:0 |
| bAddr | input | ADDR_W | Port B word address |
| bWdata | input | 18 | Port B write data |
| bOutEnN | input | 1 | Port B output enable, active low, unclocked |
| bRdata | output | 18 | Port B registered read data |
| bLaneDrv | output | 2 | Port B per-lane drive flags (1 = driven) |

## Verification
The assertions check the following on every clock:
- A deselected port raises no write or read strobe.
- A write cycle never schedules a lane drive.
- A read in the first selected cycle after a deselect stays undriven.
- The read data holds whenever no enabled read was captured.

The following can only be shown by the bench's scenarios, because they depend on memory contents:
- Lane-masked contents and cross-port visibility.
- The old-data result of a same-cycle write and read collision.
- The unclocked output-enable override.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // Strobes from a port's control stage to its datapath stage.
  typedef struct packed {
    logic [LANES-1:0] wrLane;  // lanes to write this cycle
    logic [LANES-1:0] rdLane;  // lanes to drive in the next output cycle
    logic             rdFire;  // capture a read word
  } dpl_strobe_t;
endpackage

// File: rtl/dpl_ctrl.sv
module dpl_ctrl
  import dpl_pkg::*;
#(
  parameter int WAKE_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             cs,
  input  logic             rdWrN,
  input  logic [LANES-1:0] laneN,
  output dpl_strobe_t      strobe
);
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);

  logic              sel;
  logic [WAKE_W-1:0] wake;
  logic [WAKE_W-1:0] wakeNext;
  logic              awakeNext;
  dpl_strobe_t       strobeNext;

  assign sel = !csN && cs;

  always_comb begin
    if (!sel)                               wakeNext = '0;
    else if (wake == WAKE_W'(WAKE_CYC))     wakeNext = wake;
    else                                    wakeNext = wake + 1'b1;
  end

  assign awakeNext = (wakeNext == WAKE_W'(WAKE_CYC));

  always_comb begin
    strobeNext        = '0;
    strobeNext.wrLane = (sel && !rdWrN) ? ~laneN : '0;
    strobeNext.rdFire = sel && rdWrN && awakeNext;
    strobeNext.rdLane = strobeNext.rdFire ? ~laneN : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wake   <= '0;
      strobe <= '0;
    end else begin
      wake   <= wakeNext;
      strobe <= strobeNext;
    end
  end

  // R1: a deselected cycle raises no strobe
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> (strobe.wrLane == '0 && strobe.rdLane == '0 && !strobe.rdFire));

  // R4: a write cycle never schedules a drive
  a_r4_write_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (sel && !rdWrN) |=> (strobe.rdLane == '0));

  // R6: first selected cycle after a deselect is not driven
  a_r6_wake_gap: assert property (@(posedge clk) disable iff (!rstN)
    (!sel ##1 sel) |=> !strobe.rdFire);
endmodule

// File: rtl/dpl_data.sv
module dpl_data
  import dpl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpl_strobe_t       strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [WORD_W-1:0] wdataIn,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] peerAddr,
  input  logic [WORD_W-1:0] peerWordIn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] peerQ,
  output logic [WORD_W-1:0] rdata,
  output logic [LANES-1:0]  laneDrv
);
  localparam int DEPTH = 1 << ADDR_W;

  // This port's bank; the stored word is the XOR of both banks.
  logic [WORD_W-1:0] bank [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] wdataQ;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] rdataQ;
  logic [LANES-1:0]  drvQ;

  assign regAddr = addrQ;
  assign peerQ   = bank[peerAddr];
  assign word    = bank[addrQ] ^ peerWordIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else begin
      addrQ  <= addrIn;
      wdataQ <= wdataIn;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (strobe.wrLane[l])
        bank[addrQ][l*LANE_W +: LANE_W] <=
          wdataQ[l*LANE_W +: LANE_W] ^ peerWordIn[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      drvQ   <= '0;
    end else begin
      if (strobe.rdFire) rdataQ <= word;
      drvQ <= strobe.rdLane;
    end
  end

  assign rdata   = rdataQ;
  assign laneDrv = outEnN ? '0 : drvQ;

  // R10: read data holds when no read was captured
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdFire |=> $stable(rdata));
endmodule

// File: rtl/dpl_ram.sv
module dpl_ram
  import dpl_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WAKE_CYC = 2
) (
  input  logic              aClk,
  input  logic              aRstN,
  input  logic              aCsN,
  input  logic              aCs,
  input  logic              aRdWrN,
  input  logic [LANES-1:0]  aLaneN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [WORD_W-1:0] aWdata,
  input  logic              aOutEnN,
  output logic [WORD_W-1:0] aRdata,
  output logic [LANES-1:0]  aLaneDrv,
  input  logic              bClk,
  input  logic              bRstN,
  input  logic              bCsN,
  input  logic              bCs,
  input  logic              bRdWrN,
  input  logic [LANES-1:0]  bLaneN,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [WORD_W-1:0] bWdata,
  input  logic              bOutEnN,
  output logic [WORD_W-1:0] bRdata,
  output logic [LANES-1:0]  bLaneDrv
);
  localparam int PORTS = 2;

  logic              clkV    [PORTS];
  logic              rstV    [PORTS];
  logic              csNV    [PORTS];
  logic              csV     [PORTS];
  logic              rwV     [PORTS];
  logic [LANES-1:0]  laneNV  [PORTS];
  logic [ADDR_W-1:0] addrV   [PORTS];
  logic [WORD_W-1:0] wdV     [PORTS];
  logic              oeNV    [PORTS];
  logic [WORD_W-1:0] rdV     [PORTS];
  logic [LANES-1:0]  drvV    [PORTS];
  logic [ADDR_W-1:0] regAddrV[PORTS];
  logic [WORD_W-1:0] peerQV  [PORTS];
  dpl_strobe_t       strobeV [PORTS];

  assign clkV[0] = aClk;    assign clkV[1] = bClk;
  assign rstV[0] = aRstN;   assign rstV[1] = bRstN;
  assign csNV[0] = aCsN;    assign csNV[1] = bCsN;
  assign csV[0]  = aCs;     assign csV[1]  = bCs;
  assign rwV[0]  = aRdWrN;  assign rwV[1]  = bRdWrN;
  assign laneNV[0] = aLaneN; assign laneNV[1] = bLaneN;
  assign addrV[0] = aAddr;  assign addrV[1] = bAddr;
  assign wdV[0]  = aWdata;  assign wdV[1]  = bWdata;
  assign oeNV[0] = aOutEnN; assign oeNV[1] = bOutEnN;
  assign aRdata  = rdV[0];  assign bRdata  = rdV[1];
  assign aLaneDrv = drvV[0]; assign bLaneDrv = drvV[1];

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    dpl_ctrl #(.WAKE_CYC(WAKE_CYC)) u_ctrl (
      .clk   (clkV[p]),
      .rstN  (rstV[p]),
      .csN   (csNV[p]),
      .cs    (csV[p]),
      .rdWrN (rwV[p]),
      .laneN (laneNV[p]),
      .strobe(strobeV[p])
    );

    dpl_data #(.ADDR_W(ADDR_W)) u_data (
      .clk       (clkV[p]),
      .rstN      (rstV[p]),
      .strobe    (strobeV[p]),
      .addrIn    (addrV[p]),
      .wdataIn   (wdV[p]),
      .outEnN    (oeNV[p]),
      .peerAddr  (regAddrV[PORTS-1-p]),
      .peerWordIn(peerQV[PORTS-1-p]),
      .regAddr   (regAddrV[p]),
      .peerQ     (peerQV[p]),
      .rdata     (rdV[p]),
      .laneDrv   (drvV[p])
    );
  end
endmodule

// File: tb/sim_dpl_ram.sv
`timescale 1ns/1ps
module sim_dpl_ram;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic aCsN, aCs, aRdWrN, aOutEnN, bCsN, bCs, bRdWrN, bOutEnN;
  logic [1:0] aLaneN, bLaneN, aLaneDrv, bLaneDrv;
  logic [AW-1:0] aAddr, bAddr;
  logic [17:0] aWdata, bWdata, aRdata, bRdata;

  dpl_ram #(.ADDR_W(AW)) u0 (
    .aClk(clk), .aRstN(rstN), .aCsN(aCsN), .aCs(aCs), .aRdWrN(aRdWrN),
    .aLaneN(aLaneN), .aAddr(aAddr), .aWdata(aWdata), .aOutEnN(aOutEnN),
    .aRdata(aRdata), .aLaneDrv(aLaneDrv),
    .bClk(clk), .bRstN(rstN), .bCsN(bCsN), .bCs(bCs), .bRdWrN(bRdWrN),
    .bLaneN(bLaneN), .bAddr(bAddr), .bWdata(bWdata), .bOutEnN(bOutEnN),
    .bRdata(bRdata), .bLaneDrv(bLaneDrv)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [17:0] model [0:15];
  logic [17:0] held;

  // {addr[3:0], laneN[1:0], data[17:0]}: write on A, read back on B
  localparam logic [23:0] VECS [0:7] = '{
    {4'd1, 2'b00, 18'h12345},
    {4'd2, 2'b00, 18'h0ABCD},
    {4'd3, 2'b00, 18'h3FFFF},
    {4'd4, 2'b00, 18'h00000},
    {4'd1, 2'b10, 18'h2A1FF},
    {4'd2, 2'b01, 18'h15555},
    {4'd3, 2'b11, 18'h00000},
    {4'd4, 2'b00, 18'h2D2D2}
  };

  task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  // idle = selected write with both lanes disabled: no write, no read
  task automatic idleA();
    aCsN = 0; aCs = 1; aRdWrN = 0; aLaneN = 2'b11; aAddr = '0; aWdata = '0;
  endtask
  task automatic idleB();
    bCsN = 0; bCs = 1; bRdWrN = 0; bLaneN = 2'b11; bAddr = '0; bWdata = '0;
  endtask

  task automatic modelWrite(input int ad, input logic [1:0] ln, input logic [17:0] d);
    if (!ln[0]) model[ad][8:0]  = d[8:0];
    if (!ln[1]) model[ad][17:9] = d[17:9];
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    aOutEnN = 0; bOutEnN = 0;
    idleA(); idleB();
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) cyc();
    // R9: reset state
    chk("R9 rdata in reset", {aRdata[17:2], aLaneDrv | bLaneDrv}, 18'h0);
    chk("R9 rdata B in reset", bRdata, 18'h0);
    rstN = 1;
    cyc(); cyc();  // two selected cycles to wake (R6)

    // Table: write on A, read on B (R2, R3, R7)
    for (int v = 0; v < 8; v++) begin
      aCsN = 0; aCs = 1; aRdWrN = 0;
      aAddr = AW'(VECS[v][23:20]); aLaneN = VECS[v][19:18]; aWdata = VECS[v][17:0];
      modelWrite(int'(VECS[v][23:20]), VECS[v][19:18], VECS[v][17:0]);
      cyc();
      idleA();
      bRdWrN = 1; bLaneN = 2'b00; bAddr = AW'(VECS[v][23:20]);
      cyc();
      idleB();
      cyc();
      chk($sformatf("R2 R3 R7 vector %0d", v), bRdata, model[VECS[v][23:20]]);
    end

    // R6: wake after a deselect on B
    bCsN = 1; cyc();
    bCsN = 0; bRdWrN = 1; bLaneN = 2'b00; bAddr = AW'(1); cyc();
    cyc();
    chk("R6 first selected read undriven", {16'h0, bLaneDrv}, 18'h0);
    idleB(); cyc();
    chk("R6 second selected read driven", {16'h0, bLaneDrv}, 18'h3);
    chk("R3 R6 data after wake", bRdata, model[1]);
    held = bRdata;
    // R5: unclocked output enable
    bOutEnN = 1; #1;
    chk("R5 output enable forces undriven", {16'h0, bLaneDrv}, 18'h0);
    bOutEnN = 0; #1;
    chk("R5 drive restored", {16'h0, bLaneDrv}, 18'h3);
    cyc();
    // R10 and R4: a write cycle keeps data and drives nothing
    chk("R4 write cycle undriven", {16'h0, bLaneDrv}, 18'h0);
    chk("R10 rdata held", bRdata, held);

    // R4: lane-masked read, upper lane only
    bRdWrN = 1; bLaneN = 2'b01; bAddr = AW'(2); cyc();
    idleB(); cyc();
    chk("R4 upper-only drive flags", {16'h0, bLaneDrv}, 18'h2);
    chk("R4 upper lane data", {9'h0, bRdata[17:9]}, {9'h0, model[2][17:9]});

    // R1: writes with deselecting combinations are ignored
    aCsN = 0; aCs = 0; aRdWrN = 0; aLaneN = 2'b00; aAddr = AW'(2); aWdata = 18'h3C3C3; cyc();
    aCsN = 1; aCs = 1; cyc();
    idleA(); cyc(); cyc();
    bRdWrN = 1; bLaneN = 2'b00; bAddr = AW'(2); cyc();
    idleB(); cyc();
    chk("R1 deselected write ignored", bRdata, model[2]);

    // R8: same-cycle write on A and read on B
    aRdWrN = 0; aLaneN = 2'b00; aAddr = AW'(4); aWdata = 18'h1E1E1;
    bRdWrN = 1; bLaneN = 2'b00; bAddr = AW'(4);
    cyc();
    idleA(); idleB(); cyc();
    chk("R8 collision returns old", bRdata, model[4]);
    modelWrite(4, 2'b00, 18'h1E1E1);
    bRdWrN = 1; bLaneN = 2'b00; bAddr = AW'(4); cyc();
    idleB(); cyc();
    chk("R8 later read returns new", bRdata, model[4]);

    // R7: write on B, read on A
    bRdWrN = 0; bLaneN = 2'b00; bAddr = AW'(7); bWdata = 18'h2B00D; cyc();
    modelWrite(7, 2'b00, 18'h2B00D);
    idleB();
    aRdWrN = 1; aLaneN = 2'b00; aAddr = AW'(7); cyc();
    idleA(); cyc();
    chk("R7 B to A visibility", aRdata, model[7]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule